// File: doc/BRIEF.md
# Crossing-Tagged Hit Sorter

This block takes a stream of 24-bit hit words on a single clock and files each one into a small FIFO chosen by the 6-bit beam-crossing tag carried inside the word. There is one FIFO for each tag value, so the hits from the most recent 64 crossings are held side by side. A readout sequencer outside the block names a slot and drains it through a read port.

Slots are reused when the crossing counter wraps. Each slot carries an *armed* flag and a *live* flag, both driven by a per-slot age timer that counts `bco_tick` pulses from the first accepted hit. If a hit arrives for a slot that is not armed, and its tag equals the current crossing number, it opens a new crossing. That hit empties the slot, clears its overflow flag, restarts the timer and is stored as the first entry. A slot whose live flag has dropped holds expired hits, and a read of that slot reports them as expired and returns no data.

The read port is a four-state machine. `RD_IDLE` moves to `RD_CHECK` when `rd_start` is seen, and latches `rd_slot`. `RD_CHECK` moves to `RD_DONE` if the slot is not live (this sets the expired mark) or if the slot is empty; otherwise it moves to `RD_STREAM`. `RD_STREAM` pops one word each cycle and stays there while the slot is live and not empty. It moves to `RD_DONE` when the slot becomes empty, or with the expired mark when the slot's live flag drops. `RD_DONE` always returns to `RD_IDLE`. One cycle after `RD_DONE`, `rd_done` pulses, together with `rd_expired` when the expired mark is set.

Top module: `hbuf_sorter`

## Requirements
- R1: The slot of a hit is the value in bits [9:4] of the word. A read of a slot returns its stored words in the order they arrived.
- R2: A hit word equal to 0x000000 is an idle filler and is never stored.
- R3: A hit for a slot that is not armed is dropped when its tag differs from `cur_bco`.
- R4: A hit accepted into a slot that is not armed discards the slot's earlier contents and clears its overflow flag before it is stored as the only entry.
- R5: An armed slot accepts hits whatever the value of `cur_bco`.
- R6: A slot's armed flag clears on the ARM_TICKS-th `bco_tick` after its opening hit, and its live flag clears on the LIVE_TICKS-th.
- R7: A read of a slot that is not live returns no words and raises `rd_expired` in the same cycle as `rd_done`.
- R8: A hit for a slot that already holds DEPTH words is dropped, and bit n of `ovf_flags` (n = slot) is set and stays set until R4 clears it.
- R9: After reset, `ovf_flags` is zero and `rd_busy`, `out_valid`, `rd_done` and `rd_expired` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and reads |
| rst_n | input | 1 | Active-low synchronous reset |
| bco_tick | input | 1 | One pulse for each beam crossing; advances the slot timers |
| cur_bco | input | 6 | Current crossing number |
| hit_valid | input | 1 | A hit word is present on `hit_word` |
| hit_word | input | 24 | Hit word; tag in bits [9:4] |
| rd_start | input | 1 | Starts a drain of slot `rd_slot` |
| rd_slot | input | 6 | Slot to drain |
| rd_busy | output | 1 | Read machine is not idle |
| out_valid | output | 1 | `out_word` carries a drained hit |
| out_word | output | 24 | Drained hit word |
| rd_done | output | 1 | One-cycle pulse that ends a drain |
| rd_expired | output | 1 | Drain ended because the slot had expired |
| ovf_flags | output | 64 | Sticky overflow flag for each slot |

## Verification
A full sweep writes two distinct words into each of the 64 slots, with the crossing number set to match, and drains every slot. This separates correct tag decoding and ordering from any cross-slot aliasing. Further patterns set arming against matching and separate the two: a mismatched tag for a cold slot, a mismatched tag for an armed slot, and a matching tag for a slot after it has disarmed, which must discard stale hits. Timer boundaries are probed one tick before and at each threshold. A burst of DEPTH+2 words into one slot shows that the first DEPTH survive, that only that slot's overflow bit rises, and that the bit clears when the slot opens its next crossing.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_CHECK,
        RD_STREAM,
        RD_DONE
    } rd_state_e;

endpackage

// File: rtl/hbuf_ingress.sv
module hbuf_ingress #(
    parameter int WORD_W  = 24,
    parameter int TAG_LSB = 4,
    parameter int TAG_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [WORD_W-1:0] hit_word,
    input  logic [TAG_W-1:0]  cur_bco,
    output logic              s_valid,
    output logic [WORD_W-1:0] s_word,
    output logic [TAG_W-1:0]  s_slot,
    output logic              s_match
);

    logic [TAG_W-1:0] tag;
    assign tag = hit_word[TAG_LSB +: TAG_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_word  <= '0;
            s_slot  <= '0;
            s_match <= 1'b0;
        end else begin
            s_valid <= hit_valid && (hit_word != '0);
            s_word  <= hit_word;
            s_slot  <= tag;
            s_match <= (tag == cur_bco);
        end
    end

    // R2: fillers never reach the slot logic
    p_no_idle_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> (s_word != '0));

endmodule

// File: rtl/hbuf_slot_ctrl.sv
module hbuf_slot_ctrl #(
    parameter int TAG_W      = 6,
    parameter int DEPTH      = 16,
    parameter int ARM_TICKS  = 2,
    parameter int LIVE_TICKS = 8,
    localparam int NSLOT  = 1 << TAG_W,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int TMR_W  = $clog2(LIVE_TICKS + 1),
    localparam int ADDR_W = TAG_W + PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_slot,
    input  logic              in_match,
    input  logic              pop,
    input  logic [TAG_W-1:0]  rd_slot,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_live,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [NSLOT-1:0]  ovf
);

    logic [NSLOT-1:0] armed, live;
    logic [TMR_W-1:0] tmr  [NSLOT];
    logic [PTR_W-1:0] wptr [NSLOT];
    logic [PTR_W-1:0] rptr [NSLOT];
    logic [CNT_W-1:0] cnt  [NSLOT];

    logic accept, first, full, pop_ok;
    logic [NSLOT-1:0] is_first, do_push, do_pop, do_ovf;
    logic [TMR_W-1:0] t_inc [NSLOT];

    always_comb begin
        accept  = in_valid && (armed[in_slot] || in_match);
        first   = accept && !armed[in_slot];
        full    = !first && (cnt[in_slot] == CNT_W'(DEPTH));
        wr_en   = accept && !full;
        wr_addr = {in_slot, (first ? PTR_W'(0) : wptr[in_slot])};
        pop_ok  = pop && (cnt[rd_slot] != '0);
        rd_addr = {rd_slot, rptr[rd_slot]};
        rd_live = live[rd_slot];
        rd_cnt  = cnt[rd_slot];
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign is_first[g] = first  && (in_slot == TAG_W'(g));
        assign do_push[g]  = wr_en  && (in_slot == TAG_W'(g));
        assign do_pop[g]   = pop_ok && (rd_slot == TAG_W'(g));
        assign do_ovf[g]   = accept && full && (in_slot == TAG_W'(g));
        assign t_inc[g]    = tmr[g] + TMR_W'(1);

        p_live_covers_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            armed[g] |-> live[g]);
        p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] <= CNT_W'(DEPTH));
        p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[g] && !is_first[g]) |=> ovf[g]);
        p_open_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            is_first[g] |=> (!ovf[g] && cnt[g] == CNT_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= '0;
            live  <= '0;
            ovf   <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                tmr[i]  <= '0;
                wptr[i] <= '0;
                rptr[i] <= '0;
                cnt[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (is_first[i]) begin
                    armed[i] <= 1'b1;
                    live[i]  <= 1'b1;
                    ovf[i]   <= 1'b0;
                    tmr[i]   <= '0;
                    wptr[i]  <= PTR_W'(1);
                    rptr[i]  <= '0;
                    cnt[i]   <= CNT_W'(1);
                end else begin
                    if (tick && live[i]) begin
                        tmr[i] <= t_inc[i];
                        if (t_inc[i] == TMR_W'(ARM_TICKS))  armed[i] <= 1'b0;
                        if (t_inc[i] == TMR_W'(LIVE_TICKS)) live[i]  <= 1'b0;
                    end
                    if (do_push[i]) wptr[i] <= wptr[i] + PTR_W'(1);
                    if (do_pop[i])  rptr[i] <= rptr[i] + PTR_W'(1);
                    if (do_push[i] && !do_pop[i])
                        cnt[i] <= cnt[i] + CNT_W'(1);
                    else if (!do_push[i] && do_pop[i])
                        cnt[i] <= cnt[i] - CNT_W'(1);
                    if (do_ovf[i]) ovf[i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hbuf_store.sv
module hbuf_store #(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 10,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/hbuf_reader.sv
module hbuf_reader
    import hbuf_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int TAG_W  = 6,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic [TAG_W-1:0]  rd_slot_in,
    input  logic              slot_live,
    input  logic [CNT_W-1:0]  slot_cnt,
    input  logic [WORD_W-1:0] rdata,
    output logic [TAG_W-1:0]  sel_slot,
    output logic              pop,
    output logic              busy,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              rd_done,
    output logic              rd_expired
);

    rd_state_e state, state_nx;
    logic      exp_q, exp_nx;

    always_comb begin
        state_nx = state;
        exp_nx   = exp_q;
        unique case (state)
            RD_IDLE: begin
                exp_nx = 1'b0;
                if (rd_start) state_nx = RD_CHECK;
            end
            RD_CHECK, RD_STREAM: begin
                if (!slot_live) begin
                    state_nx = RD_DONE;
                    exp_nx   = 1'b1;
                end else if (slot_cnt == '0) begin
                    state_nx = RD_DONE;
                end else begin
                    state_nx = RD_STREAM;
                end
            end
            RD_DONE: state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RD_IDLE;
            exp_q    <= 1'b0;
            sel_slot <= '0;
        end else begin
            state <= state_nx;
            exp_q <= exp_nx;
            if (state == RD_IDLE && rd_start) sel_slot <= rd_slot_in;
        end
    end

    assign pop  = (state == RD_STREAM) && slot_live && (slot_cnt != '0);
    assign busy = (state != RD_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_word   <= '0;
            rd_done    <= 1'b0;
            rd_expired <= 1'b0;
        end else begin
            out_valid  <= pop;
            out_word   <= pop ? rdata : '0;
            rd_done    <= (state == RD_DONE);
            rd_expired <= (state == RD_DONE) && exp_q;
        end
    end

    p_expired_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_expired |-> rd_done);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
    p_data_only_when_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

endmodule

// File: rtl/hbuf_sorter.sv
module hbuf_sorter #(
    parameter int WORD_W     = 24,
    parameter int TAG_LSB    = 4,
    parameter int TAG_W      = 6,
    parameter int DEPTH      = 16,
    parameter int ARM_TICKS  = 2,
    parameter int LIVE_TICKS = 8,
    localparam int NSLOT  = 1 << TAG_W,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = TAG_W + PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bco_tick,
    input  logic [TAG_W-1:0]  cur_bco,
    input  logic              hit_valid,
    input  logic [WORD_W-1:0] hit_word,
    input  logic              rd_start,
    input  logic [TAG_W-1:0]  rd_slot,
    output logic              rd_busy,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              rd_done,
    output logic              rd_expired,
    output logic [NSLOT-1:0]  ovf_flags
);

    logic              s_valid, s_match;
    logic [WORD_W-1:0] s_word;
    logic [TAG_W-1:0]  s_slot, sel_slot;
    logic              wr_en, pop, rd_live;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [CNT_W-1:0]  rd_cnt;
    logic [WORD_W-1:0] rdata;

    hbuf_ingress #(.WORD_W(WORD_W), .TAG_LSB(TAG_LSB), .TAG_W(TAG_W)) ingress_i (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_word(hit_word),
        .cur_bco(cur_bco), .s_valid(s_valid), .s_word(s_word),
        .s_slot(s_slot), .s_match(s_match)
    );

    hbuf_slot_ctrl #(.TAG_W(TAG_W), .DEPTH(DEPTH), .ARM_TICKS(ARM_TICKS),
                     .LIVE_TICKS(LIVE_TICKS)) slots_i (
        .clk(clk), .rst_n(rst_n), .tick(bco_tick), .in_valid(s_valid),
        .in_slot(s_slot), .in_match(s_match), .pop(pop), .rd_slot(sel_slot),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .rd_live(rd_live), .rd_cnt(rd_cnt), .ovf(ovf_flags)
    );

    hbuf_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) store_i (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(s_word),
        .rd_addr(rd_addr), .rd_data(rdata)
    );

    hbuf_reader #(.WORD_W(WORD_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) reader_i (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_slot_in(rd_slot),
        .slot_live(rd_live), .slot_cnt(rd_cnt), .rdata(rdata),
        .sel_slot(sel_slot), .pop(pop), .busy(rd_busy), .out_valid(out_valid),
        .out_word(out_word), .rd_done(rd_done), .rd_expired(rd_expired)
    );

endmodule

// File: tb/hbuf_sorter_tb_top.sv
module hbuf_sorter_tb_top;

    localparam int DEPTH = 16;
    localparam int ARM   = 2;
    localparam int LIVE  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bco_tick = 1'b0;
    logic [5:0]  cur_bco = '0;
    logic        hit_valid = 1'b0;
    logic [23:0] hit_word = '0;
    logic        rd_start = 1'b0;
    logic [5:0]  rd_slot = '0;
    logic        rd_busy, out_valid, rd_done, rd_expired;
    logic [23:0] out_word;
    logic [63:0] ovf_flags;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [23:0] got [0:31];
    int  got_n;
    bit  got_exp;

    always #2.5 clk = ~clk;

    hbuf_sorter #(.DEPTH(DEPTH), .ARM_TICKS(ARM), .LIVE_TICKS(LIVE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bco_tick(bco_tick), .cur_bco(cur_bco),
        .hit_valid(hit_valid), .hit_word(hit_word), .rd_start(rd_start),
        .rd_slot(rd_slot), .rd_busy(rd_busy), .out_valid(out_valid),
        .out_word(out_word), .rd_done(rd_done), .rd_expired(rd_expired),
        .ovf_flags(ovf_flags)
    );

    function automatic logic [23:0] mk(input int s, input int k);
        return {6'(k + 1), 8'h5A, 6'(s), 4'h3};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic send(input logic [23:0] w);
        @(negedge clk);
        hit_valid = 1'b1;
        hit_word  = w;
        @(negedge clk);
        hit_valid = 1'b0;
        hit_word  = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bco_tick = 1'b1;
            @(negedge clk);
            bco_tick = 1'b0;
        end
    endtask

    task automatic drain(input int s);
        got_n = 0;
        got_exp = 1'b0;
        @(negedge clk);
        rd_slot  = 6'(s);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (out_valid && got_n < 32) begin
                got[got_n] = out_word;
                got_n++;
            end
            if (rd_done) begin
                got_exp = rd_expired;
                return;
            end
        end
        chk(1'b0, "R7 drain timeout", 0, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(1'b0, "watchdog", cyc, 0);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(ovf_flags == '0, "R9 ovf", ovf_flags, 0);
        chk({rd_busy, out_valid, rd_done, rd_expired} == 4'b0, "R9 outputs",
            {rd_busy, out_valid, rd_done, rd_expired}, 0);

        // R1 sweep over every slot
        for (int s = 0; s < 64; s++) begin
            cur_bco = 6'(s);
            send(mk(s, 0));
            send(mk(s, 1));
        end
        for (int s = 0; s < 64; s++) begin
            drain(s);
            chk(got_n == 2 && got[0] == mk(s, 0) && got[1] == mk(s, 1) && !got_exp,
                $sformatf("R1 sweep slot %0d", s), {got_n[7:0], got[0]},
                {8'd2, mk(s, 0)});
        end
        tick(LIVE);

        // R1 worked examples of tag decoding
        cur_bco = 6'h15; send(24'h2EE551);
        cur_bco = 6'h00; send(24'h1EE001);
        drain(6'h15);
        chk(got_n == 1 && got[0] == 24'h2EE551, "R1 slot 0x15", got[0], 24'h2EE551);
        drain(0);
        chk(got_n == 1 && got[0] == 24'h1EE001, "R1 slot 0x00", got[0], 24'h1EE001);
        tick(LIVE);

        // R2 filler is not stored (would arm slot 0 with one word)
        cur_bco = 0;
        send(24'h000000);
        drain(0);
        chk(got_n == 0, "R2 zero word dropped", got_n, 0);

        // R3 cold slot, tag mismatch
        cur_bco = 9;
        send(mk(7, 0));
        drain(7);
        chk(got_n == 0, "R3 mismatch dropped", got_n, 0);

        // R5 armed slot accepts under a different crossing number
        cur_bco = 10; send(mk(10, 0));
        cur_bco = 11; send(mk(10, 1));
        drain(10);
        chk(got_n == 2 && got[1] == mk(10, 1), "R5 armed accept", got_n, 2);
        tick(LIVE);

        // R4 reopened slot discards stale contents
        cur_bco = 20; send(mk(20, 0)); send(mk(20, 1));
        tick(ARM);
        send(mk(20, 2));
        drain(20);
        chk(got_n == 1 && got[0] == mk(20, 2), "R4 stale cleared", got[0], mk(20, 2));
        tick(LIVE);

        // R6 arm window boundary
        cur_bco = 12; send(mk(12, 0));
        tick(ARM - 1);
        cur_bco = 13; send(mk(12, 1));
        tick(1);
        send(mk(12, 2));
        drain(12);
        chk(got_n == 2 && got[1] == mk(12, 1), "R6 arm boundary", got_n, 2);
        tick(LIVE);

        // R6/R7 live window boundary
        cur_bco = 31; send(mk(31, 0)); send(mk(31, 1));
        tick(LIVE - 1);
        drain(31);
        chk(got_n == 2 && !got_exp, "R6 live before limit", got_n, 2);
        cur_bco = 32; send(mk(31, 3));
        tick(1);
        drain(31);
        chk(got_n == 0 && got_exp, "R7 expired read", {got_n[7:0], 7'b0, got_exp}, 1);
        tick(LIVE);

        // R8 overflow
        cur_bco = 40;
        for (int k = 0; k < DEPTH + 2; k++) send(mk(40, k));
        chk(ovf_flags == (64'd1 << 40), "R8 ovf flag", ovf_flags, 64'd1 << 40);
        drain(40);
        chk(got_n == DEPTH && got[0] == mk(40, 0) && got[DEPTH-1] == mk(40, DEPTH-1),
            "R8 first DEPTH kept", got_n, DEPTH);
        chk(ovf_flags == (64'd1 << 40), "R8 ovf sticky", ovf_flags, 64'd1 << 40);
        tick(ARM);
        send(mk(40, 50));
        chk(ovf_flags == '0, "R4 ovf cleared on reopen", ovf_flags, 0);
        drain(40);
        chk(got_n == 1 && got[0] == mk(40, 50), "R4 reopen content", got[0], mk(40, 50));

        report();
        $finish;
    end

endmodule